// File: doc/BRIEF.md
# Write-Through Direct-Mapped Data Cache

This block is a direct-mapped data cache that sits between a 32-bit byte-addressed processor and a word-wide main memory. Each line holds a block of four 32-bit words. A load that hits returns its word in the cycle it is presented. A load that misses fetches the whole block from memory, one word at a time and in ascending word order. It installs the line and then completes the access.

Stores use a write-through policy. An accepted store updates the line only when the line is already resident; a store that misses does not allocate a line. Every store is also queued in a small FIFO write buffer, which drains to memory in the background. When that buffer is full, the processor is held off. A single request/acknowledge memory port is shared between buffer drains and block refills. A refill never starts while the buffer still holds a write to the block being fetched, so stale memory contents can never be loaded.

The line count is set by `INDEX_W`. With `INDEX_W = 12` the arrays form the 64 KB arrangement: 4096 lines and a 16-bit tag. The default build uses `INDEX_W = 8` (256 lines, 20-bit tag) to keep the storage small.

Top module: `dcache_wt`

## Requirements
- R1: Address fields are: word-in-block offset at bits 3:2, line index at bits 4+INDEX_W-1:4, tag at bits 31:4+INDEX_W. Bits 1:0 do not select anything; byte lanes come from `cpu_be`. Two addresses with the same index but different tags evict each other.
- R2: A load hits when the indexed line is valid and its stored tag equals the address tag. A hit raises `cpu_ready` in the same cycle and returns the word picked by bits 3:2 on `cpu_rdata`, with no memory traffic.
- R3: A load miss issues exactly four memory reads (`mem_we` = 0). The word addresses are block base +0, +4, +8 and +12, in that order. The access completes, with the requested word, after the fourth acknowledge.
- R4: An accepted store whose line is resident rewrites only the byte lanes enabled in `cpu_be` (bit i selects bits 8i+7:8i). A store that misses leaves the cache untouched, so a later load of that address still misses.
- R5: Every accepted store is written to memory exactly once, in acceptance order, with its word address, data and byte enables (`mem_we` = 1).
- R6: The write buffer holds WB_DEPTH entries (default 4). A store presented while the buffer is full sees `cpu_ready` low until an entry drains.
- R7: No refill read is issued while the buffer holds a write to the block being refilled.
- R8: Once `mem_req` is raised, it and `mem_we`, `mem_addr`, `mem_wdata` and `mem_be` hold steady until the cycle in which `mem_ack` is seen.
- R9: After reset all lines are invalid, the buffer is empty and `mem_req` is low.
- R10: A store presented while the buffer has room and no refill is in progress is accepted in that same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_req | input | 1 | Processor access request, held until accepted |
| cpu_we | input | 1 | 1 = store, 0 = load |
| cpu_addr | input | 32 | Byte address |
| cpu_wdata | input | 32 | Store data |
| cpu_be | input | 4 | Store byte-lane enables |
| cpu_rdata | output | 32 | Load data, valid while `cpu_ready` is high on a load |
| cpu_ready | output | 1 | Access completes this cycle; low means stall |
| mem_req | output | 1 | Memory word request |
| mem_we | output | 1 | 1 = buffer drain write, 0 = refill read |
| mem_addr | output | 32 | Word-aligned memory address |
| mem_wdata | output | 32 | Write data |
| mem_be | output | 4 | Write byte enables |
| mem_rdata | input | 32 | Read data, valid with `mem_ack` |
| mem_ack | input | 1 | Memory completes the current request this cycle |

## Verification
The assertions assume a processor that holds `cpu_req`, `cpu_addr`, `cpu_we`, `cpu_wdata` and `cpu_be` steady until `cpu_ready`. They also assume a memory that acknowledges only while `mem_req` is high and returns read data alongside the acknowledge. The bench drives the processor side from a task that changes those inputs only after an accepted cycle. Its memory model counts a programmable latency from the request and raises the acknowledge for one cycle. Addresses stay within a 16 KB window so that a handful of indices and tags alias heavily.

// File: rtl/cache_pkg.sv
package cache_pkg;

  localparam int WORD_W  = 32;
  localparam int WORDS   = 4;
  localparam int WOFF_W  = 2;
  localparam int LANES   = WORD_W / 8;

  typedef enum logic {ST_IDLE, ST_FILL} ctl_state_t;

  // one pending store: word address, data, byte lanes
  typedef struct packed {
    logic [29:0]       waddr;
    logic [WORD_W-1:0] data;
    logic [LANES-1:0]  be;
  } wb_entry_t;

  function automatic logic [WORD_W-1:0] merge_bytes(
    input logic [WORD_W-1:0] old_w,
    input logic [WORD_W-1:0] new_w,
    input logic [LANES-1:0]  be);
    logic [WORD_W-1:0] r;
    r = old_w;
    for (int b = 0; b < LANES; b++)
      if (be[b]) r[b*8 +: 8] = new_w[b*8 +: 8];
    return r;
  endfunction

endpackage

// File: rtl/wt_line_store.sv
module wt_line_store
  import cache_pkg::*;
#(
  parameter int INDEX_W = 8,
  parameter int TAG_W   = 20
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [INDEX_W-1:0]      rd_index,
  input  logic [WOFF_W-1:0]       rd_woff,
  output logic                    rd_valid,
  output logic [TAG_W-1:0]        rd_tag,
  output logic [WORD_W-1:0]       rd_word,
  input  logic                    fill_we,
  input  logic [INDEX_W-1:0]      fill_index,
  input  logic [TAG_W-1:0]        fill_tag,
  input  logic [WORDS*WORD_W-1:0] fill_line,
  input  logic                    st_we,
  input  logic [INDEX_W-1:0]      st_index,
  input  logic [WOFF_W-1:0]       st_woff,
  input  logic [WORD_W-1:0]       st_data,
  input  logic [LANES-1:0]        st_be
);
  localparam int LINES = 1 << INDEX_W;

  logic [LINES-1:0]  valid_q;
  logic [TAG_W-1:0]  tag_q  [LINES];
  logic [WORD_W-1:0] data_q [LINES][WORDS];

  always_ff @(posedge clk) begin
    if (!rst_n)       valid_q <= '0;
    else if (fill_we) valid_q[fill_index] <= 1'b1;
  end

  always_ff @(posedge clk) begin
    if (fill_we) begin
      tag_q[fill_index] <= fill_tag;
      for (int w = 0; w < WORDS; w++)
        data_q[fill_index][w] <= fill_line[w*WORD_W +: WORD_W];
    end else if (st_we) begin
      data_q[st_index][st_woff] <= merge_bytes(data_q[st_index][st_woff], st_data, st_be);
    end
  end

  assign rd_valid = valid_q[rd_index];
  assign rd_tag   = tag_q[rd_index];
  assign rd_word  = data_q[rd_index][rd_woff];

endmodule

// File: rtl/wt_write_buffer.sv
module wt_write_buffer
  import cache_pkg::*;
#(
  parameter int DEPTH = 4
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        push,
  input  wb_entry_t   push_entry,
  input  logic        pop,
  output wb_entry_t   head,
  output logic        empty,
  output logic        full,
  input  logic [27:0] q_blk,
  output logic        blk_match
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = PTR_W + 1;
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(DEPTH);
  localparam logic [PTR_W-1:0] PTR_LAST = PTR_W'(DEPTH - 1);

  wb_entry_t        slot_q [DEPTH];
  logic [DEPTH-1:0] vld_q;
  logic [PTR_W-1:0] wr_ptr_q, rd_ptr_q;
  logic [CNT_W-1:0] cnt_q;

  function automatic logic [PTR_W-1:0] ptr_next(input logic [PTR_W-1:0] p);
    return (p == PTR_LAST) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vld_q    <= '0;
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      cnt_q    <= '0;
    end else begin
      if (push) begin
        slot_q[wr_ptr_q] <= push_entry;
        vld_q[wr_ptr_q]  <= 1'b1;
        wr_ptr_q         <= ptr_next(wr_ptr_q);
      end
      if (pop) begin
        vld_q[rd_ptr_q] <= 1'b0;
        rd_ptr_q        <= ptr_next(rd_ptr_q);
      end
      case ({push, pop})
        2'b10:   cnt_q <= cnt_q + 1'b1;
        2'b01:   cnt_q <= cnt_q - 1'b1;
        default: cnt_q <= cnt_q;
      endcase
    end
  end

  assign head  = slot_q[rd_ptr_q];
  assign empty = (cnt_q == '0);
  assign full  = (cnt_q == CNT_FULL);

  always_comb begin
    blk_match = 1'b0;
    for (int i = 0; i < DEPTH; i++)
      if (vld_q[i] && (slot_q[i].waddr[29:2] == q_blk)) blk_match = 1'b1;
  end

  // R6: the controller never pushes into a full buffer
  a_r6_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    push |-> !full);
  // R5: drains only come from occupied slots
  a_r5_no_underflow: assert property (@(posedge clk) disable iff (!rst_n)
    pop |-> !empty);
  a_r6_count_matches_slots: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(vld_q) == int'(cnt_q));

endmodule

// File: rtl/wt_refill_seq.sv
module wt_refill_seq
  import cache_pkg::*;
#(
  parameter int BLK_W = 28
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    start,
  input  logic [BLK_W-1:0]        blk_in,
  input  logic                    ack,
  input  logic [WORD_W-1:0]       rdata,
  output logic                    busy,
  output logic [31:0]             word_addr,
  output logic                    done,
  output logic [WORDS*WORD_W-1:0] line_out
);
  localparam logic [WOFF_W-1:0] CNT_LAST = WOFF_W'(WORDS - 1);

  logic                busy_q;
  logic [BLK_W-1:0]    blk_q;
  logic [WOFF_W-1:0]   cnt_q;
  logic [WORD_W-1:0]   words_q [WORDS-1];

  assign busy      = busy_q;
  assign done      = busy_q && ack && (cnt_q == CNT_LAST);
  assign word_addr = {blk_q, cnt_q, 2'b00};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
      blk_q  <= '0;
    end else if (start) begin
      busy_q <= 1'b1;
      cnt_q  <= '0;
      blk_q  <= blk_in;
    end else if (busy_q && ack) begin
      cnt_q <= cnt_q + 1'b1;
      if (cnt_q == CNT_LAST) busy_q <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (busy_q && ack)
      for (int w = 0; w < WORDS - 1; w++)
        if (cnt_q == WOFF_W'(w)) words_q[w] <= rdata;
  end

  // the last word bypasses the holding registers
  for (genvar g = 0; g < WORDS - 1; g++) begin : g_line
    assign line_out[g*WORD_W +: WORD_W] = words_q[g];
  end
  assign line_out[(WORDS-1)*WORD_W +: WORD_W] = rdata;

  // R3: words are requested in ascending order, one per acknowledge
  a_r3_word_order: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q && ack && (cnt_q != CNT_LAST) |=> busy_q && (cnt_q == $past(cnt_q) + 1'b1));
  a_r3_no_restart: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q |-> !start);

endmodule

// File: rtl/dcache_wt.sv
module dcache_wt
  import cache_pkg::*;
#(
  parameter int INDEX_W  = 8,
  parameter int WB_DEPTH = 4
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cpu_req,
  input  logic        cpu_we,
  input  logic [31:0] cpu_addr,
  input  logic [31:0] cpu_wdata,
  input  logic [3:0]  cpu_be,
  output logic [31:0] cpu_rdata,
  output logic        cpu_ready,
  output logic        mem_req,
  output logic        mem_we,
  output logic [31:0] mem_addr,
  output logic [31:0] mem_wdata,
  output logic [3:0]  mem_be,
  input  logic [31:0] mem_rdata,
  input  logic        mem_ack
);
  localparam int OFF_W = WOFF_W + 2;
  localparam int TAG_W = 32 - INDEX_W - OFF_W;
  localparam int BLK_W = 32 - OFF_W;

  function automatic logic [TAG_W-1:0] tag_of(input logic [31:0] a);
    return a[31 -: TAG_W];
  endfunction
  function automatic logic [INDEX_W-1:0] index_of(input logic [31:0] a);
    return a[OFF_W +: INDEX_W];
  endfunction
  function automatic logic [WOFF_W-1:0] woff_of(input logic [31:0] a);
    return a[2 +: WOFF_W];
  endfunction

  logic unused_byte_off;
  assign unused_byte_off = ^cpu_addr[1:0];

  ctl_state_t state_q;

  // named internal events
  logic              rd_valid, lookup_hit, rd_req, wr_req, in_idle;
  logic [TAG_W-1:0]  rd_tag;
  logic              fill_start, fill_busy, fill_done, st_accept, st_hit_wr;
  logic              wb_empty, wb_full, wb_match, wb_pop, wb_port_free;
  logic [31:0]       fill_addr;
  logic [WORDS*WORD_W-1:0] fill_line;
  wb_entry_t         wb_head, wb_new;

  assign rd_req  = cpu_req && !cpu_we;
  assign wr_req  = cpu_req && cpu_we;
  assign in_idle = (state_q == ST_IDLE);

  wt_line_store #(.INDEX_W(INDEX_W), .TAG_W(TAG_W)) u_store (
    .clk       (clk),
    .rst_n     (rst_n),
    .rd_index  (index_of(cpu_addr)),
    .rd_woff   (woff_of(cpu_addr)),
    .rd_valid  (rd_valid),
    .rd_tag    (rd_tag),
    .rd_word   (cpu_rdata),
    .fill_we   (fill_done),
    .fill_index(index_of(cpu_addr)),
    .fill_tag  (tag_of(cpu_addr)),
    .fill_line (fill_line),
    .st_we     (st_hit_wr),
    .st_index  (index_of(cpu_addr)),
    .st_woff   (woff_of(cpu_addr)),
    .st_data   (cpu_wdata),
    .st_be     (cpu_be)
  );

  assign lookup_hit = rd_valid && (rd_tag == tag_of(cpu_addr));

  // a refill may only take the port when no drain is waiting on it
  assign wb_port_free = wb_empty || mem_ack;
  assign fill_start   = in_idle && rd_req && !lookup_hit && !wb_match && wb_port_free;
  assign st_accept    = in_idle && wr_req && !wb_full;
  assign st_hit_wr    = st_accept && lookup_hit;
  assign wb_pop       = in_idle && !wb_empty && mem_ack;
  assign cpu_ready    = in_idle && ((rd_req && lookup_hit) || st_accept);

  assign wb_new = '{waddr: cpu_addr[31:2], data: cpu_wdata, be: cpu_be};

  wt_write_buffer #(.DEPTH(WB_DEPTH)) u_wbuf (
    .clk       (clk),
    .rst_n     (rst_n),
    .push      (st_accept),
    .push_entry(wb_new),
    .pop       (wb_pop),
    .head      (wb_head),
    .empty     (wb_empty),
    .full      (wb_full),
    .q_blk     (cpu_addr[31:OFF_W]),
    .blk_match (wb_match)
  );

  wt_refill_seq #(.BLK_W(BLK_W)) u_fill (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (fill_start),
    .blk_in   (cpu_addr[31:OFF_W]),
    .ack      (mem_ack),
    .rdata    (mem_rdata),
    .busy     (fill_busy),
    .word_addr(fill_addr),
    .done     (fill_done),
    .line_out (fill_line)
  );

  always_ff @(posedge clk) begin
    if (!rst_n)          state_q <= ST_IDLE;
    else if (fill_start) state_q <= ST_FILL;
    else if (fill_done)  state_q <= ST_IDLE;
  end

  always_comb begin
    if (state_q == ST_FILL) begin
      mem_req   = fill_busy;
      mem_we    = 1'b0;
      mem_addr  = fill_addr;
      mem_wdata = '0;
      mem_be    = '1;
    end else begin
      mem_req   = !wb_empty;
      mem_we    = 1'b1;
      mem_addr  = {wb_head.waddr, 2'b00};
      mem_wdata = wb_head.data;
      mem_be    = wb_head.be;
    end
  end

  // R8: an outstanding request is held until acknowledged
  a_r8_mem_hold: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_ack |=> mem_req && $stable(mem_we) && $stable(mem_addr)
                            && $stable(mem_wdata) && $stable(mem_be));
  // R6: a full buffer stalls stores
  a_r6_full_stall: assert property (@(posedge clk) disable iff (!rst_n)
    wr_req && wb_full |-> !cpu_ready);
  // R7: while refilling, no buffered write targets the block
  a_r7_fill_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_FILL) && $stable(cpu_addr) |-> !wb_match);
  // R3: refill traffic is read-only
  a_r3_fill_reads: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_FILL) && mem_req |-> !mem_we);
  // R3/R2: the installed line serves the held load next cycle
  a_r3_fill_then_hit: assert property (@(posedge clk) disable iff (!rst_n)
    $past(fill_done) && rd_req && $stable(cpu_addr) |-> cpu_ready);
  // R9: no memory traffic while idle with an empty buffer
  a_r9_quiet_when_empty: assert property (@(posedge clk) disable iff (!rst_n)
    in_idle && wb_empty |-> !mem_req);

endmodule

// File: tb/dcache_wt_tb_top.sv
module dcache_wt_tb_top;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        cpu_req, cpu_we;
  logic [31:0] cpu_addr, cpu_wdata, cpu_rdata;
  logic [3:0]  cpu_be;
  logic        cpu_ready;
  logic        mem_req, mem_we, mem_ack;
  logic [31:0] mem_addr, mem_wdata, mem_rdata;
  logic [3:0]  mem_be;

  always #10 clk = ~clk;

  dcache_wt dut_i (
    .clk(clk), .rst_n(rst_n),
    .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_addr(cpu_addr),
    .cpu_wdata(cpu_wdata), .cpu_be(cpu_be), .cpu_rdata(cpu_rdata),
    .cpu_ready(cpu_ready),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_be(mem_be), .mem_rdata(mem_rdata),
    .mem_ack(mem_ack)
  );

  int n_checks = 0;
  int n_fail   = 0;

  logic [31:0] ref_mem   [4096];  // architectural view
  logic [31:0] mem_model [4096];  // what memory actually holds
  logic [29:0] exp_wa [$];
  logic [31:0] exp_wd [$];
  logic [3:0]  exp_be [$];

  int          mem_lat = 0;
  int          lat_cnt = 0;
  int          rd_acks = 0;
  int          fill_pos = 0;
  logic [27:0] fill_blk = '0;
  logic        prev_pend = 1'b0;
  logic [31:0] prev_addr = '0;
  logic        prev_we = 1'b0;

  task automatic chk(input bit ok, input string rq, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", rq, what, act, exp);
    end
  endtask

  function automatic logic [31:0] lane_mix(input logic [31:0] o, input logic [31:0] n,
                                           input logic [3:0] be);
    logic [31:0] m;
    m = {{8{be[3]}}, {8{be[2]}}, {8{be[1]}}, {8{be[0]}}};
    return (o & ~m) | (n & m);
  endfunction

  // memory model: decides acknowledges at the falling edge
  initial begin
    mem_ack = 1'b0;
    mem_rdata = '0;
    forever begin
      @(negedge clk);
      if (prev_pend)
        chk(mem_req && mem_addr == prev_addr && mem_we == prev_we,
            "R8", "request held", mem_addr, prev_addr);
      mem_ack = 1'b0;
      if (!rst_n) lat_cnt = 0;
      else if (mem_req) begin
        if (lat_cnt >= mem_lat) begin
          mem_ack = 1'b1;
          lat_cnt = 0;
          if (mem_we) begin
            if (exp_wa.size() == 0)
              chk(1'b0, "R5", "unexpected write", mem_addr, 32'h0);
            else begin
              chk(mem_addr[31:2] == exp_wa[0], "R5", "write address", mem_addr, {exp_wa[0], 2'b00});
              chk(mem_wdata == exp_wd[0] && mem_be == exp_be[0], "R5", "write data",
                  mem_wdata, exp_wd[0]);
              void'(exp_wa.pop_front());
              void'(exp_wd.pop_front());
              void'(exp_be.pop_front());
            end
            mem_model[mem_addr[13:2]] = lane_mix(mem_model[mem_addr[13:2]], mem_wdata, mem_be);
          end else begin
            rd_acks++;
            mem_rdata = mem_model[mem_addr[13:2]];
            chk(int'(mem_addr[3:2]) == fill_pos, "R3", "refill word order",
                {30'd0, mem_addr[3:2]}, fill_pos);
            if (fill_pos == 0) begin
              fill_blk = mem_addr[31:4];
              for (int i = 0; i < exp_wa.size(); i++)
                chk(exp_wa[i][29:2] != fill_blk, "R7", "refill before drain",
                    {exp_wa[i], 2'b00}, 32'h0);
            end else
              chk(mem_addr[31:4] == fill_blk, "R3", "refill block", mem_addr, {fill_blk, 4'h0});
            fill_pos = (fill_pos + 1) % 4;
          end
        end else lat_cnt++;
      end
      prev_pend = rst_n && mem_req && !mem_ack;
      prev_addr = mem_addr;
      prev_we   = mem_we;
    end
  end

  task automatic cpu_op(input bit we, input logic [31:0] a, input logic [31:0] wd,
                        input logic [3:0] be, output int waited, output logic [31:0] rd);
    waited = 0;
    @(negedge clk);
    cpu_req = 1'b1; cpu_we = we; cpu_addr = a; cpu_wdata = wd; cpu_be = be;
    #1;
    while (!cpu_ready) begin
      @(negedge clk);
      #1;
      waited++;
    end
    rd = cpu_rdata;
    if (we) begin
      exp_wa.push_back(a[31:2]);
      exp_wd.push_back(wd);
      exp_be.push_back(be);
      ref_mem[a[13:2]] = lane_mix(ref_mem[a[13:2]], wd, be);
    end
    @(posedge clk);
  endtask

  task automatic go_idle();
    @(negedge clk);
    cpu_req = 1'b0;
  endtask

  task automatic load_chk(input logic [31:0] a, input string rq, output int waited);
    logic [31:0] rd;
    cpu_op(1'b0, a, 32'h0, 4'h0, waited, rd);
    chk(rd == ref_mem[a[13:2]], rq, "load data", rd, ref_mem[a[13:2]]);
  endtask

  task automatic wait_drain();
    while (exp_wa.size() != 0) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    chk(1'b0, "R9", "watchdog expired", 32'd150000, 32'd0);
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    int w, r0;
    logic [31:0] rd;
    for (int i = 0; i < 4096; i++) begin
      mem_model[i] = (i * 32'h9E3779B1) ^ 32'h5A5A0F0F;
      ref_mem[i]   = mem_model[i];
    end
    rst_n = 1'b0; cpu_req = 1'b0; cpu_we = 1'b0;
    cpu_addr = '0; cpu_wdata = '0; cpu_be = '0;
    repeat (4) @(negedge clk);
    #1;
    chk(!mem_req, "R9", "mem_req in reset", {31'd0, mem_req}, 32'd0);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk(!mem_req, "R9", "mem_req after reset", {31'd0, mem_req}, 32'd0);

    // cold miss: four ordered reads, then the word
    r0 = rd_acks;
    load_chk(32'h0000_0104, "R3", w);
    chk(rd_acks - r0 == 4, "R9", "cold line refilled", rd_acks - r0, 4);
    chk(w >= 4, "R3", "miss stall cycles", w, 4);

    // hits within the same block
    r0 = rd_acks;
    load_chk(32'h0000_0104, "R2", w);
    chk(w == 0, "R2", "hit same cycle", w, 0);
    load_chk(32'h0000_010C, "R2", w);
    chk(w == 0 && rd_acks == r0, "R2", "hit other word", w, 0);

    // store hit with partial lanes (R4), accepted at once (R10)
    cpu_op(1'b1, 32'h0000_0108, 32'hDEAD_BEEF, 4'b0101, w, rd);
    chk(w == 0, "R10", "store accepted", w, 0);
    load_chk(32'h0000_0108, "R4", w);
    chk(w == 0, "R4", "merged word hits", w, 0);

    // store miss: no allocation
    cpu_op(1'b1, 32'h0000_2200, 32'h1234_5678, 4'hF, w, rd);
    go_idle();
    wait_drain();
    r0 = rd_acks;
    load_chk(32'h0000_2200, "R4", w);
    chk(rd_acks - r0 == 4, "R4", "store miss left line absent", rd_acks - r0, 4);

    // buffered write to the block being refilled
    mem_lat = 6;
    cpu_op(1'b1, 32'h0000_3304, 32'hCAFE_F00D, 4'hF, w, rd);
    load_chk(32'h0000_3304, "R7", w);
    go_idle();
    wait_drain();

    // buffer full stall
    mem_lat = 15;
    for (int k = 0; k < 4; k++) begin
      cpu_op(1'b1, 32'h0000_0400 + 32'(k * 16), 32'hA000_0000 + 32'(k), 4'hF, w, rd);
      chk(w == 0, "R10", "store into free slot", w, 0);
    end
    cpu_op(1'b1, 32'h0000_0500, 32'hB000_0001, 4'hF, w, rd);
    chk(w > 0, "R6", "store stalled on full buffer", w, 1);
    go_idle();
    wait_drain();
    mem_lat = 0;

    // aliasing: same index, different tag
    r0 = rd_acks;
    load_chk(32'h0000_1104, "R1", w);
    chk(rd_acks - r0 == 4, "R1", "alias evicts", rd_acks - r0, 4);
    r0 = rd_acks;
    load_chk(32'h0000_0104, "R1", w);
    chk(rd_acks - r0 == 4, "R1", "original refetched", rd_acks - r0, 4);

    // mixed traffic over a small aliasing set
    for (int n = 0; n < 400; n++) begin
      logic [31:0] a;
      a = {18'd0, 2'($urandom_range(0, 3)), 6'd0, 2'($urandom_range(0, 3)),
           2'($urandom_range(0, 3)), 2'b00};
      mem_lat = $urandom_range(0, 3);
      if ($urandom_range(0, 2) == 0)
        cpu_op(1'b1, a, $urandom, 4'($urandom_range(1, 15)), w, rd);
      else
        load_chk(a, "R5", w);
      if ($urandom_range(0, 7) == 0) go_idle();
    end
    go_idle();
    wait_drain();
    begin
      int bad;
      bad = 0;
      for (int i = 0; i < 4096; i++) if (mem_model[i] != ref_mem[i]) bad++;
      chk(bad == 0, "R5", "memory image after drain", bad, 0);
    end

    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

endmodule